// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Tone Detector

This block keeps a sensor node's radio almost entirely powered down while a network is dormant. It repeatedly sleeps with the receiver off, then turns the receiver on for a brief probe window whose length matches the radio's turn-on time. It samples a digitized RF-activity line during that window. If nothing is heard, the receiver goes off again for the next long sleep interval. With the default timing (a 200 µs probe every 4 s at a 1 MHz clock) the receiver is on roughly 0.005 % of the time.

When activity appears during a probe, the receiver stays powered and the block moves to a confirmation listen. It accepts the wake-up tone only if activity stays high for a set number of consecutive samples (1 ms by default). Otherwise it returns to sleep. On confirmation it emits a one-cycle wake pulse to the rest of the node, leaves the receiver on, and remains awake until enable is withdrawn. A wake-up tone that lasts longer than one sleep-plus-probe period overlaps every node's probe, so a whole network wakes well inside a 20 s budget. All durations are parameters, so a bench can scale them down.

Top module: `tone_wake_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the state output is 0 (sleep), radio_en is 0 and wake_pulse is 0.
- R2: With enable high and the block asleep, radio_en stays 0 and state reads 0 for exactly SLEEP_CYCLES clock cycles. The block then enters the probe state.
- R3: In the probe state, state reads 1 and radio_en is 1 for at most PROBE_CYCLES cycles. If rf_active is never sampled high in that window, the block returns to sleep.
- R4: A high rf_active sample in any probe cycle moves the block to the confirm state (state 2) on the next cycle, with radio_en still 1.
- R5: When rf_active is sampled high on CONFIRM_SAMPLES consecutive confirm cycles, the block enters the awake state (state 3) on the next cycle.
- R6: A low rf_active sample in the confirm state before that count is reached returns the block to sleep, with radio_en 0 for a full SLEEP_CYCLES period and no wake pulse.
- R7: wake_pulse is high for exactly one cycle, the first awake cycle. radio_en then stays 1, and no further pulse occurs while enable stays high.
- R8: Enable low moves the block to sleep with radio_en 0 on the next cycle, from any state, and holds it there whatever rf_active does. After enable returns high, a full SLEEP_CYCLES sleep precedes the next probe.
- R9: A tone that starts at any phase of the sleep/probe cycle and stays high produces a wake pulse within SLEEP_CYCLES + PROBE_CYCLES + CONFIRM_SAMPLES + 2 cycles of its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic acts on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the duty cycle when high; forces sleep when low |
| rf_active | input | 1 | Digitized RF-energy indication from the receiver, synchronous to clk |
| radio_en | output | 1 | Receiver power enable |
| wake_pulse | output | 1 | One-cycle pulse when a wake-up tone is confirmed |
| state_o | output | 2 | Controller state: 0 sleep, 1 probe, 2 confirm, 3 awake |

## Verification
The detector is driven with silence, to separate correct sleep and probe lengths from off-by-one timer loads. It is driven with a tone held through confirmation, which shows whether the consecutive-sample count is exact. It is driven with a tone that drops one sample short, which tells a consecutive count from a running total. A steady tone is also started at random phases of the sleep/probe cycle to bound the wake latency. A long stretch of random activity bursts with occasional enable drops is compared cycle by cycle against a bench model, which exposes wrong transitions in rare orderings such as activity on the last probe cycle or enable falling during confirmation.

// File: rtl/twk_pkg.sv
package twk_pkg;

    typedef enum logic [1:0] {
        TW_SLEEP   = 2'd0,
        TW_PROBE   = 2'd1,
        TW_CONFIRM = 2'd2,
        TW_AWAKE   = 2'd3
    } tw_state_e;

    typedef struct packed {
        tw_state_e state;
        logic      radio;
        logic      wake;
    } tw_regs_t;

    // Bits needed to hold the values 0 .. span-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned span);
        return (span > 1) ? $clog2(span) : 1;
    endfunction

endpackage

// File: rtl/twk_interval_timer.sv
// Down counter shared by the sleep and probe intervals.
module twk_interval_timer #(
    parameter int unsigned           WIDTH     = 8,
    parameter logic [WIDTH-1:0]      RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RESET_VAL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R2: each decrement request moves the interval exactly one step closer.
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && dec && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: a load is what the next cycle holds.
    assert_timer_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/twk_run_counter.sv
// Counts consecutive high activity samples during confirmation.
module twk_run_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic last
);

    localparam int unsigned W   = twk_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (clear) begin
            run_d = '0;
        end else if (inc && (run_q != TOP)) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign last = (run_q == TOP);

    // R5: a clear always restarts the run from zero.
    assert_run_clear_R5: assert property (@(posedge clk) disable iff (rst)
        clear |=> (run_q == '0));

    // R5: a counted sample advances the run by one until the limit is hit.
    assert_run_step_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && !clear && !last) |=> (run_q == $past(run_q) + 1'b1));

endmodule

// File: rtl/tone_wake_ctrl.sv
module tone_wake_ctrl #(
    parameter int unsigned SLEEP_CYCLES    = 4_000_000,
    parameter int unsigned PROBE_CYCLES    = 200,
    parameter int unsigned CONFIRM_SAMPLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       rf_active,
    output logic       radio_en,
    output logic       wake_pulse,
    output logic [1:0] state_o
);

    import twk_pkg::*;

    localparam int unsigned SPAN     = (SLEEP_CYCLES > PROBE_CYCLES) ? SLEEP_CYCLES : PROBE_CYCLES;
    localparam int unsigned TW       = cnt_width(SPAN);
    localparam logic [TW-1:0] SLEEP_LD = TW'(SLEEP_CYCLES - 1);
    localparam logic [TW-1:0] PROBE_LD = TW'(PROBE_CYCLES - 1);

    tw_regs_t        cur_q, nxt_d;
    logic            tmr_load, tmr_dec, tmr_expired;
    logic [TW-1:0]   tmr_val;
    logic            run_clr, run_inc, run_last;

    twk_interval_timer #(
        .WIDTH     (TW),
        .RESET_VAL (SLEEP_LD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .expired  (tmr_expired)
    );

    twk_run_counter #(
        .LIMIT (CONFIRM_SAMPLES)
    ) u_run (
        .clk   (clk),
        .rst   (rst),
        .clear (run_clr),
        .inc   (run_inc),
        .last  (run_last)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.wake = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = SLEEP_LD;
        tmr_dec    = 1'b0;
        run_clr    = 1'b0;
        run_inc    = 1'b0;
        if (!enable) begin
            nxt_d.state = TW_SLEEP;
            tmr_load    = 1'b1;
            run_clr     = 1'b1;
        end else begin
            unique case (cur_q.state)
                TW_SLEEP: begin
                    if (tmr_expired) begin
                        nxt_d.state = TW_PROBE;
                        tmr_load    = 1'b1;
                        tmr_val     = PROBE_LD;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
                TW_PROBE: begin
                    if (rf_active) begin
                        nxt_d.state = TW_CONFIRM;
                        run_clr     = 1'b1;
                    end else if (tmr_expired) begin
                        nxt_d.state = TW_SLEEP;
                        tmr_load    = 1'b1;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
                TW_CONFIRM: begin
                    if (!rf_active) begin
                        nxt_d.state = TW_SLEEP;
                        tmr_load    = 1'b1;
                    end else if (run_last) begin
                        nxt_d.state = TW_AWAKE;
                        nxt_d.wake  = 1'b1;
                    end else begin
                        run_inc = 1'b1;
                    end
                end
                default: begin
                    nxt_d.state = TW_AWAKE;
                end
            endcase
        end
        nxt_d.radio = (nxt_d.state != TW_SLEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{state: TW_SLEEP, radio: 1'b0, wake: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign radio_en   = cur_q.radio;
    assign wake_pulse = cur_q.wake;
    assign state_o    = cur_q.state;

    // R3: a probe is only ever entered from sleep.
    assert_probe_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == TW_PROBE && $past(cur_q.state) != TW_PROBE)
            |-> ($past(cur_q.state) == TW_SLEEP));

    // R4: confirmation starts only after activity was seen in a probe.
    assert_confirm_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == TW_CONFIRM && $past(cur_q.state) == TW_PROBE)
            |-> $past(rf_active));

    // R5: awake is reached only from confirm with activity still high, and with the pulse.
    assert_awake_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == TW_AWAKE && $past(cur_q.state) != TW_AWAKE)
            |-> ($past(cur_q.state) == TW_CONFIRM && $past(rf_active) && wake_pulse));

    // R6: losing activity during confirmation drops back to sleep.
    assert_confirm_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == TW_CONFIRM && enable && !rf_active)
            |=> (state_o == TW_SLEEP && !radio_en));

    // R7: the wake indication never lasts two cycles.
    assert_wake_single_R7: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    // R8: withdrawing enable forces sleep with the receiver off.
    assert_disable_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state_o == TW_SLEEP && !radio_en && !wake_pulse));

endmodule

// File: tb/tone_wake_ctrl_bench.sv
module tone_wake_ctrl_bench;

    localparam int S = 20;
    localparam int P = 4;
    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       rf_active = 1'b0;
    logic       radio_en, wake_pulse;
    logic [1:0] state_o;

    int  checks = 0;
    int  fails  = 0;
    bit  chk_on = 1'b0;
    bit  ended  = 1'b0;

    always #5 clk = ~clk;

    tone_wake_ctrl #(
        .SLEEP_CYCLES    (S),
        .PROBE_CYCLES    (P),
        .CONFIRM_SAMPLES (N)
    ) u_tone_wake_ctrl (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .rf_active  (rf_active),
        .radio_en   (radio_en),
        .wake_pulse (wake_pulse),
        .state_o    (state_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Bench model of the required behaviour (states: 0 sleep, 1 probe, 2 confirm, 3 awake).
    int    m_st  = 0;
    int    m_cnt = S - 1;
    int    m_run = 0;
    bit    m_wk  = 1'b0;
    string m_tag = "R1";

    function automatic string tag_of(input int st, input bit wk);
        case (st)
            0:       return "R2";
            1:       return "R3";
            2:       return "R5";
            default: return wk ? "R7" : "R5";
        endcase
    endfunction

    always @(posedge clk) begin
        int st;
        int cnt;
        int run;
        bit wk;
        st = m_st; cnt = m_cnt; run = m_run; wk = 1'b0;
        if (rst) begin
            st = 0; cnt = S - 1; run = 0; m_tag = "R1";
        end else if (!enable) begin
            st = 0; cnt = S - 1; run = 0; m_tag = "R8";
        end else begin
            case (st)
                0: if (cnt == 0) begin st = 1; cnt = P - 1; end else cnt = cnt - 1;
                1: if (rf_active) begin st = 2; run = 0; end
                   else if (cnt == 0) begin st = 0; cnt = S - 1; end
                   else cnt = cnt - 1;
                2: if (!rf_active) begin st = 0; cnt = S - 1; end
                   else if (run == N - 1) begin st = 3; wk = 1'b1; end
                   else run = run + 1;
                default: st = 3;
            endcase
            m_tag = tag_of(st, wk);
        end
        m_st = st; m_cnt = cnt; m_run = run; m_wk = wk;
    end

    always @(negedge clk) begin
        if (chk_on) begin
            check(m_tag, "state/radio/wake vs model",
                  32'({state_o, radio_en, wake_pulse}),
                  32'({m_st[1:0], (m_st != 0), m_wk}));
        end
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        int wk_seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_on = 1'b1;
        check("R1", "reset outputs", 32'({state_o, radio_en, wake_pulse}), 32'd0);

        // R2 / R3: silent channel from reset release.
        rst = 1'b0; enable = 1'b1;
        check("R1", "first cycle after reset", 32'({state_o, radio_en, wake_pulse}), 32'd0);
        n = 0;
        while (!radio_en && n < S + 10) begin n++; @(negedge clk); end
        check("R2", "sleep length from reset", n, S);
        check("R3", "probe state code", state_o, 1);
        n = 0;
        while (radio_en && n < P + 10) begin n++; @(negedge clk); end
        check("R3", "probe length with silence", n, P);
        n = 0;
        while (!radio_en && n < S + 10) begin n++; @(negedge clk); end
        check("R2", "sleep length after probe", n, S);

        // R4 / R5 / R7: tone held through confirmation.
        rf_active = 1'b1;
        @(negedge clk);
        check("R4", "confirm entered", state_o, 2);
        check("R4", "radio kept on", radio_en, 1);
        n = 0;
        while (!wake_pulse && n < N + 10) begin n++; @(negedge clk); end
        check("R5", "confirm cycles before wake", n, N);
        check("R5", "awake state code", state_o, 3);
        wk_seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            rf_active = 1'($urandom_range(0, 1));
            if (wake_pulse) wk_seen++;
            if (!radio_en || state_o != 2'd3) wk_seen += 100;
        end
        check("R7", "no extra pulse, radio on while awake", wk_seen, 0);

        // R8: enable withdrawn from awake.
        enable = 1'b0;
        @(negedge clk);
        check("R8", "sleep after disable", 32'({state_o, radio_en}), 32'd0);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            rf_active = 1'b1;
            @(negedge clk);
            if (radio_en) n++;
        end
        check("R8", "radio off while disabled", n, 0);
        enable = 1'b1; rf_active = 1'b0;
        n = 0;
        while (!radio_en && n < S + 10) begin n++; @(negedge clk); end
        check("R8", "full sleep after re-enable", n, S);

        // R6: tone drops one sample short of confirmation.
        rf_active = 1'b1;
        @(negedge clk);
        wk_seen = 0;
        repeat (N - 1) begin
            @(negedge clk);
            if (wake_pulse) wk_seen++;
        end
        rf_active = 1'b0;
        @(negedge clk);
        if (wake_pulse) wk_seen++;
        check("R6", "back to sleep on drop", 32'({state_o, radio_en}), 32'd0);
        n = 0;
        while (!radio_en && n < S + 10) begin
            n++;
            if (wake_pulse) wk_seen++;
            @(negedge clk);
        end
        check("R6", "full sleep after drop", n, S);
        check("R6", "no wake pulse on short tone", wk_seen, 0);

        // R9: steady tone starting at random phases.
        for (int t = 0; t < 10; t++) begin
            rf_active = 1'b0; enable = 1'b0;
            @(negedge clk);
            enable = 1'b1;
            repeat ($urandom_range(0, S + P + 2)) @(negedge clk);
            rf_active = 1'b1;
            n = 0;
            while (!wake_pulse && n < 4 * (S + P + N)) begin n++; @(negedge clk); end
            check("R9", "tone woke the node", wake_pulse, 1);
            check("R9", "wake latency within bound", 32'(n <= S + P + N + 2), 1);
        end

        // Random soak: activity bursts and occasional enable drops, checked by the model.
        begin
            int burst_left;
            burst_left = 0;
            for (int c = 0; c < 5000; c++) begin
                if (burst_left == 0) begin
                    rf_active  = ($urandom_range(0, 3) == 0);
                    burst_left = $urandom_range(1, 2 * N + 2);
                end
                burst_left--;
                enable = ($urandom_range(0, 149) != 0);
                @(negedge clk);
            end
        end
        finish_run();
    end

endmodule